// File: doc/BRIEF.md
# Queue-Based Target Capacity Scaler

This block sets how much of the link capacity left over for available-bit-rate traffic may be handed out to sources, based on how full the queue for that traffic is. It maps the current queue length to a scaling fraction and multiplies the total capacity by that fraction. The result is the target capacity that the rate allocator then divides among the active connections. When the queue is short, the fraction sits above one, so the allocator offers more than the link can carry and the queue fills toward its target. When the queue is long, the fraction drops below one, and the spare capacity drains the backlog. The fraction never falls below a programmable drain floor.

Two truncated rectangular hyperbolas make up the curve, and both equal exactly one at the target queue length Q0. Q0 is the target delay multiplied by the link rate. Below Q0 the fraction is f = a·Q0 / ((a−1)·Q + Q0). Above Q0 it is max(floor, b·Q0 / ((b−1)·Q + Q0)). Setting b to one removes the upper curve. All fractions use unsigned fixed point with FRAC_BITS fractional bits (default 8, so 256 means 1.0) and INT_BITS integer bits. A pulse on the request input captures one set of operands. A sequential restoring divider then works out the fraction, and the outputs are held until the next accepted request has been computed.

Top module: `qcs_target_scaler`

## Requirements
- R1: For 0 < Q ≤ Q0 the fraction is floor(a·Q0·256 / ((a−256)·Q + 256·Q0)), with a in fixed point and a ≥ 256. It lies between 256 and a.
- R2: At Q = 0 the fraction equals a exactly. At Q = Q0 (Q0 > 0) it equals 256 exactly.
- R3: For Q > Q0 with b > 256 the fraction is max(floor, floor(b·Q0·256 / ((b−256)·Q + 256·Q0))). It is never below the floor input, and this includes Q0 = 0.
- R4: For Q > Q0 with b ≤ 256 the fraction is exactly 256.
- R5: The target capacity output equals floor(fraction · capacity / 256) when ROUND_TGT = 0. When ROUND_TGT = 1 it is rounded to nearest instead.
- R6: The done output is high for exactly one cycle. It rises FRAC_BITS + INT_BITS + 1 rising edges after the edge that accepted the request, which is 11 with the defaults. Busy is high from the accepting edge until done rises.
- R7: A request seen while busy is high is ignored. The next results belong to the request that was accepted, and the busy period is not extended.
- R8: After reset, fraction, target, busy and done are all zero. The fraction and target outputs change only in a cycle where done is high, and otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Compute request strobe |
| queue_len_i | input | QW | Current queue length in cells |
| q_target_i | input | QW | Target queue length Q0 in cells |
| a_coef_i | input | FW | Lower-curve coefficient a, fixed point |
| b_coef_i | input | FW | Upper-curve coefficient b, fixed point |
| drain_floor_i | input | FW | Minimum fraction above Q0, fixed point |
| abr_cap_i | input | CW | Total capacity to be scaled |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result strobe |
| frac_o | output | FW | Scaling fraction, fixed point |
| tgt_cap_o | output | CW+INT_BITS | Target capacity |

## Verification
The bench targets each point where the curve changes form. At Q = 0, a design that divides there instead of bypassing would report a divide by zero or a value off by one, rather than exactly a. At Q = Q0, a wrong region boundary would give a value other than exactly 256. A very long queue, or Q0 = 0 with Q above it, would expose a floor that was skipped, because the fraction would fall below the floor. A flat upper curve (b = 1.0) would expose a divider that runs on a zero slope. Other stimulus checks that a request arriving mid-computation does not restart the work or corrupt the captured operands, and that the result latency stays fixed.

// File: rtl/qcs_pkg.sv
package qcs_pkg;

   typedef enum logic [1:0] {
      REG_BELOW_DIV  = 2'd0,
      REG_BELOW_ZERO = 2'd1,
      REG_ABOVE_DIV  = 2'd2,
      REG_ABOVE_FLAT = 2'd3
   } qcs_region_e;

   function automatic int unsigned qcs_max(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/qcs_operand_prep.sv
module qcs_operand_prep
   import qcs_pkg::*;
#(
   parameter int QW   = 16,
   parameter int FW   = 10,
   parameter int FRAC = 8,
   localparam int NW  = FW + QW + FRAC,
   localparam int DW  = FW + QW + 1
) (
   input  logic [QW-1:0] q_i,
   input  logic [QW-1:0] q0_i,
   input  logic [FW-1:0] a_i,
   input  logic [FW-1:0] b_i,
   output qcs_region_e   region_o,
   output logic [NW-1:0] num_o,
   output logic [DW-1:0] den_o
);

   localparam logic [FW-1:0] ONE = FW'(1 << FRAC);

   initial begin
      AST_PREP_FRAC_FITS: assert (FRAC >= 1 && FRAC < FW);
   end

   logic          above;
   logic [FW-1:0] coef;
   logic [FW-1:0] slope;
   logic [NW-1:0] num_raw;
   logic [DW-1:0] den_raw;

   always_comb begin
      above = (q_i > q0_i);
      if (above) begin
         coef  = b_i;
         slope = (b_i > ONE) ? (b_i - ONE) : '0;
      end else begin
         coef  = a_i;
         slope = (a_i > ONE) ? (a_i - ONE) : '0;
      end

      if (!above)
         region_o = (q_i == '0) ? REG_BELOW_ZERO : REG_BELOW_DIV;
      else
         region_o = (b_i <= ONE) ? REG_ABOVE_FLAT : REG_ABOVE_DIV;

      num_raw = (NW'(coef) * NW'(q0_i)) << FRAC;
      den_raw = DW'(slope) * DW'(q_i) + (DW'(q0_i) << FRAC);

      if (region_o == REG_BELOW_DIV || region_o == REG_ABOVE_DIV) begin
         num_o = num_raw;
         den_o = den_raw;
      end else begin
         num_o = '0;
         den_o = DW'(1);
      end
   end

endmodule

// File: rtl/qcs_seq_divider.sv
module qcs_seq_divider
   import qcs_pkg::*;
#(
   parameter int NW = 34,
   parameter int DW = 27,
   parameter int OW = 10,
   localparam int SW  = DW + OW - 1,
   localparam int XW  = (NW > SW) ? NW : SW,
   localparam int CNW = $clog2(OW + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [NW-1:0] num_i,
   input  logic [DW-1:0] den_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [OW-1:0] quot_o
);

   initial begin
      AST_DIV_WIDTHS: assert (OW >= 2 && DW >= 1 && NW >= OW);
   end

   logic [XW-1:0]  rem;
   logic [XW-1:0]  dsh;
   logic [DW-1:0]  den_r;
   logic [CNW-1:0] cnt;
   logic           fits;

   assign fits = (rem >= dsh);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem    <= '0;
         dsh    <= '0;
         den_r  <= '0;
         cnt    <= '0;
         quot_o <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
      end else if (load_i) begin
         rem    <= XW'(num_i);
         dsh    <= XW'(den_i) << (OW - 1);
         den_r  <= den_i;
         cnt    <= CNW'(OW);
         quot_o <= '0;
         busy_o <= 1'b1;
         done_o <= 1'b0;
      end else if (busy_o) begin
         if (fits) rem <= rem - dsh;
         quot_o <= {quot_o[OW-2:0], fits};
         dsh    <= dsh >> 1;
         cnt    <= cnt - CNW'(1);
         if (cnt == CNW'(1)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
         end
      end else begin
         done_o <= 1'b0;
      end
   end

   AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (rem < XW'(den_r))); // R1

   AST_NO_RELOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> !load_i); // R7

endmodule

// File: rtl/qcs_scale_out.sv
module qcs_scale_out
   import qcs_pkg::*;
#(
   parameter int FW        = 10,
   parameter int CW        = 16,
   parameter int FRAC      = 8,
   parameter bit ROUND_TGT = 1'b0,
   localparam int TW = CW + FW - FRAC,
   localparam int PW = FW + CW + 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          valid_i,
   input  qcs_region_e   region_i,
   input  logic [FW-1:0] quot_i,
   input  logic [FW-1:0] a_i,
   input  logic [FW-1:0] floor_i,
   input  logic [CW-1:0] cap_i,
   output logic [FW-1:0] frac_o,
   output logic [TW-1:0] tgt_o,
   output logic          done_o
);

   localparam logic [FW-1:0] ONE = FW'(1 << FRAC);

   logic [FW-1:0] frac_n;
   logic [PW-1:0] prod;
   logic [TW-1:0] tgt_n;

   always_comb begin
      unique case (region_i)
         REG_BELOW_DIV:  frac_n = quot_i;
         REG_BELOW_ZERO: frac_n = a_i;
         REG_ABOVE_DIV:  frac_n = (quot_i < floor_i) ? floor_i : quot_i;
         default:        frac_n = ONE;
      endcase
      prod = PW'(frac_n) * PW'(cap_i);
   end

   generate
      if (ROUND_TGT) begin : g_round
         logic [PW-1:0] biased;
         assign biased = prod + PW'(1 << (FRAC - 1));
         assign tgt_n  = TW'(biased >> FRAC);
      end else begin : g_trunc
         assign tgt_n = TW'(prod >> FRAC);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frac_o <= '0;
         tgt_o  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= valid_i;
         if (valid_i) begin
            frac_o <= frac_n;
            tgt_o  <= tgt_n;
         end
      end
   end

   AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> done_o); // R6

endmodule

// File: rtl/qcs_target_scaler.sv
module qcs_target_scaler
   import qcs_pkg::*;
#(
   parameter int QW        = 16,
   parameter int CW        = 16,
   parameter int FRAC_BITS = 8,
   parameter int INT_BITS  = 2,
   parameter bit ROUND_TGT = 1'b0,
   localparam int FW  = FRAC_BITS + INT_BITS,
   localparam int TW  = CW + INT_BITS,
   localparam int NW  = FW + QW + FRAC_BITS,
   localparam int DW  = FW + QW + 1,
   localparam int LATENCY = FW + 1,
   localparam int LCW = $clog2(LATENCY + 2) + 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          req_i,
   input  logic [QW-1:0] queue_len_i,
   input  logic [QW-1:0] q_target_i,
   input  logic [FW-1:0] a_coef_i,
   input  logic [FW-1:0] b_coef_i,
   input  logic [FW-1:0] drain_floor_i,
   input  logic [CW-1:0] abr_cap_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [FW-1:0] frac_o,
   output logic [TW-1:0] tgt_cap_o
);

   localparam logic [FW-1:0] ONE = FW'(1 << FRAC_BITS);

   initial begin
      AST_TOP_PARAMS: assert (QW >= 2 && CW >= 2 && INT_BITS >= 2 && FRAC_BITS >= 1);
   end

   qcs_region_e   region_c;
   qcs_region_e   region_r;
   logic [NW-1:0] num_c;
   logic [DW-1:0] den_c;
   logic [FW-1:0] a_r;
   logic [FW-1:0] floor_r;
   logic [CW-1:0] cap_r;
   logic          accept;
   logic          div_busy;
   logic          div_done;
   logic [FW-1:0] quot;

   assign busy_o = div_busy | div_done;
   assign accept = req_i & ~busy_o;

   qcs_operand_prep #(
      .QW   (QW),
      .FW   (FW),
      .FRAC (FRAC_BITS)
   ) i_prep (
      .q_i      (queue_len_i),
      .q0_i     (q_target_i),
      .a_i      (a_coef_i),
      .b_i      (b_coef_i),
      .region_o (region_c),
      .num_o    (num_c),
      .den_o    (den_c)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         region_r <= REG_BELOW_ZERO;
         a_r      <= '0;
         floor_r  <= '0;
         cap_r    <= '0;
      end else if (accept) begin
         region_r <= region_c;
         a_r      <= a_coef_i;
         floor_r  <= drain_floor_i;
         cap_r    <= abr_cap_i;
      end
   end

   qcs_seq_divider #(
      .NW (NW),
      .DW (DW),
      .OW (FW)
   ) i_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (accept),
      .num_i  (num_c),
      .den_i  (den_c),
      .busy_o (div_busy),
      .done_o (div_done),
      .quot_o (quot)
   );

   qcs_scale_out #(
      .FW        (FW),
      .CW        (CW),
      .FRAC      (FRAC_BITS),
      .ROUND_TGT (ROUND_TGT)
   ) i_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (div_done),
      .region_i (region_r),
      .quot_i   (quot),
      .a_i      (a_r),
      .floor_i  (floor_r),
      .cap_i    (cap_r),
      .frac_o   (frac_o),
      .tgt_o    (tgt_cap_o),
      .done_o   (done_o)
   );

   // latency checker: edges since the accepting edge
   logic [LCW-1:0] lat_cnt;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lat_cnt <= '0;
      else if (accept)   lat_cnt <= '0;
      else if (busy_o)   lat_cnt <= lat_cnt + LCW'(1);
   end

   AST_LATENCY_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (lat_cnt == LCW'(LATENCY))); // R6

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R6

   AST_CAPTURE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && req_i) |=> ($stable(cap_r) && $stable(floor_r) && $stable(a_r))); // R7

   AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(frac_o) || !$stable(tgt_cap_o)) |-> done_o); // R8

   AST_BELOW_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && region_r == REG_BELOW_DIV && a_r >= ONE) |->
         (frac_o >= ONE && frac_o <= a_r)); // R1

   AST_FLOOR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && region_r == REG_ABOVE_DIV) |-> (frac_o >= floor_r)); // R3

   AST_FLAT_UNITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && region_r == REG_ABOVE_FLAT) |-> (frac_o == ONE)); // R4

endmodule

// File: tb/test_qcs_target_scaler.sv
module test_qcs_target_scaler;

   localparam int CLK_PERIOD = 10;
   localparam int QW = 16;
   localparam int CW = 16;
   localparam int FW = 10;
   localparam int TW = 18;
   localparam int LAT = FW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [QW-1:0] q = '0;
   logic [QW-1:0] q0 = '0;
   logic [FW-1:0] a = '0;
   logic [FW-1:0] b = '0;
   logic [FW-1:0] fl = '0;
   logic [CW-1:0] cap = '0;
   logic          busy;
   logic          done;
   logic [FW-1:0] frac;
   logic [TW-1:0] tgt;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qcs_target_scaler i_qcs_target_scaler (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .req_i         (req),
      .queue_len_i   (q),
      .q_target_i    (q0),
      .a_coef_i      (a),
      .b_coef_i      (b),
      .drain_floor_i (fl),
      .abr_cap_i     (cap),
      .busy_o        (busy),
      .done_o        (done),
      .frac_o        (frac),
      .tgt_cap_o     (tgt)
   );

   function automatic longint exp_frac(longint qq, longint qt, longint aa, longint bb, longint ff);
      longint quo;
      if (qq <= qt) begin
         if (qq == 0) return aa;
         return (aa * qt * 256) / ((aa - 256) * qq + qt * 256);
      end
      if (bb <= 256) return 256;
      quo = (bb * qt * 256) / ((bb - 256) * qq + qt * 256);
      return (quo < ff) ? ff : quo;
   endfunction

   task automatic check(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic set_ops(input int qq, input int qt, input int aa, input int bb,
                          input int ff, input int cc);
      q = QW'(qq); q0 = QW'(qt); a = FW'(aa); b = FW'(bb); fl = FW'(ff); cap = CW'(cc);
   endtask

   // issue one request, optionally poke a second one mid-flight, check results
   task automatic run_op(input int qq, input int qt, input int aa, input int bb,
                         input int ff, input int cc, input string rq, input bit poke);
      longint ef, et;
      int cnt;
      ef = exp_frac(qq, qt, aa, bb, ff);
      et = (ef * cc) / 256;
      @(negedge clk);
      set_ops(qq, qt, aa, bb, ff, cc);
      req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      cnt = 0;
      while (!done && cnt < 40) begin
         if (poke && cnt == 3) begin
            set_ops(qt + 7, qt, 300, 262, 100, 1234);   // R7 ignored request
            req = 1'b1;
         end else begin
            req = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         cnt++;
      end
      req = 1'b0;
      check(cnt == LAT && done, "R6 latency", cnt, LAT);
      check(longint'(frac) == ef, rq, frac, ef);
      check(longint'(tgt) == et, "R5 target", tgt, et);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      longint hold_f, hold_t;
      seed = $urandom(32'd4711);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8 reset values
      check(frac == '0 && tgt == '0 && !busy && !done, "R8 reset", frac, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(0,     1000, 300, 264, 128, 40000, "R2 zero queue", 1'b0);
      run_op(1000,  1000, 300, 264, 128, 40000, "R2 at target", 1'b0);
      run_op(500,   1000, 300, 264, 128, 40000, "R1 below", 1'b0);
      run_op(1,     1000, 320, 264, 128, 65535, "R1 below small", 1'b0);
      run_op(5000,  1000, 300, 264, 128, 40000, "R3 above", 1'b0);
      run_op(65535, 1000, 300, 264, 128, 40000, "R3 floor", 1'b0);
      run_op(10,    0,    300, 264, 128, 40000, "R3 zero target", 1'b0);
      run_op(5000,  1000, 300, 256, 128, 40000, "R4 flat", 1'b0);
      run_op(60000, 0,    300, 256, 200, 65535, "R4 flat zero target", 1'b0);
      run_op(2000,  3000, 290, 266, 128, 50000, "R7 busy ignored", 1'b1);

      // R8 outputs hold without a request
      hold_f = frac;
      hold_t = tgt;
      repeat (20) @(negedge clk);
      check(longint'(frac) == hold_f && longint'(tgt) == hold_t, "R8 hold", frac, hold_f);

      for (int i = 0; i < 150; i++) begin
         int qt, qq;
         qt = int'($urandom_range(20000, 1));
         case ($urandom_range(3, 0))
            0: qq = int'($urandom_range(qt, 0));
            1: qq = int'($urandom_range(65535, qt + 1));
            2: qq = qt;
            default: qq = int'($urandom_range(65535, 0));
         endcase
         run_op(qq, qt, int'($urandom_range(320, 282)), int'($urandom_range(269, 256)),
                int'($urandom_range(255, 64)), int'($urandom_range(65535, 0)),
                (qq <= qt) ? "R1 random below" : "R3 random above", 1'b0);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule